// File: doc/BRIEF.md
# HDLC Serial Frame Receiver

The receiver takes a bit-serial HDLC line, one bit per clock on the cycles where the serial enable is high. It locks onto the 01111110 delimiter, strips the zero that a transmitter inserts after five ones in a row, and packs the payload into bytes with the first received bit in bit 0. Each byte is handed to a back-end through an availability flag and a read strobe. Three status outputs travel alongside the bytes: frame in progress, frame error, and frame aborted. Nothing is configurable at run time, and the core has no registers that software can reach.

A minimal bus slave sits on the same back-end. It returns the held byte on its data output and acknowledges any read strobe at once. It signals retry while no byte is waiting. There is no address, and writes are acknowledged by nothing and change nothing.

Internally three state machines run in a chain. The deframer has the states HUNT and OPEN. A delimiter moves HUNT to OPEN. A run of seven ones moves OPEN back to HUNT. The packer has the states EMPTY and BUSY. The first completed byte moves EMPTY to BUSY. A delimiter or an abort moves BUSY back to EMPTY. The back-end has the states IDLE, LIVE and DRAIN. A byte moves IDLE or DRAIN to LIVE. The end of a frame moves LIVE to DRAIN. DRAIN moves to IDLE once the last byte has been read.

Top module: `hdlc_rx_core`

## Requirements
- R1: While reset (active low, asynchronous) is held, bk_avail, frm_valid, frm_err and frm_abort are all 0, and wb_rty is 1.
- R2: Payload bytes between two delimiters (01111110) are delivered in arrival order. The first payload bit received becomes bit 0 of its byte.
- R3: A 0 that follows exactly five consecutive 1s is removed from the payload. Payload data containing runs of ones, including the delimiter pattern itself, is delivered intact.
- R4: On a cycle where ser_en is 0, ser_bit is ignored, whatever its value.
- R5: Delimiters that follow each other with no payload between them produce no byte and do not raise frm_valid.
- R6: frm_valid rises together with bk_avail for the first byte of a frame. It stays high until the frame has ended and its last byte has been read. It falls two cycles after that read at most.
- R7: If a frame's payload bit count is not a multiple of eight, frm_err is 1 after the closing delimiter. The leftover bits are dropped.
- R8: If a byte completes while the previous byte is still unread, frm_err is set for the frame. The newer byte replaces the older one.
- R9: Seven or more consecutive 1s after at least one delivered byte set frm_abort and end the frame. A run of ones on an idle line after a closed frame does not set frm_abort.
- R10: frm_err and frm_abort hold their values after a frame ends. They clear when the first byte of the next frame is delivered.
- R11: bk_avail stays 1 while a byte waits and no read occurs. A read strobe (bk_rd) while bk_avail is 1 clears it at the next edge.
- R12: wb_ack is 1 exactly when wb_stb is 1 and wb_we is 0. wb_rty is the inverse of bk_avail and wb_dat carries the held byte. An acknowledged read consumes the byte, and a write strobe leaves it in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_en | input | 1 | Serial bit qualifier, active high |
| ser_bit | input | 1 | Serial data bit |
| bk_rd | input | 1 | Back-end read strobe |
| bk_data | output | DATA_W | Held byte |
| bk_avail | output | 1 | A byte is waiting |
| frm_valid | output | 1 | Frame in progress or still draining |
| frm_err | output | 1 | Lost bits or overrun in this frame |
| frm_abort | output | 1 | Frame ended by an abort |
| wb_stb | input | 1 | Bus strobe |
| wb_we | input | 1 | Bus write enable |
| wb_dat | output | DATA_W | Bus read data |
| wb_ack | output | 1 | Bus acknowledge |
| wb_rty | output | 1 | Bus retry (no byte waiting) |

## Verification
The bench targets the seven bits of the closing delimiter that reach the deframer before the delimiter can be recognised. A design that passed them on as payload would deliver a spurious final byte or flag every frame as short. Payload containing 0xFF and the delimiter pattern checks zero deletion: if deletion were missing or mistimed, bytes would shift or the frame would be cut early. A test with the enable gapped and random data on the line catches a design that samples disabled cycles. Back-to-back delimiters, a short frame, an overrun and an abort that follows a flushing byte each exercise one status path. A wrong design would show a phantom frame, a missing error, the older of two bytes, or an abort raised on an idle line.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    typedef enum logic {
        DF_HUNT,
        DF_OPEN
    } dfr_state_t;

    typedef enum logic {
        PK_EMPTY,
        PK_BUSY
    } pk_state_t;

    typedef enum logic [1:0] {
        BE_IDLE,
        BE_LIVE,
        BE_DRAIN
    } be_state_t;

endpackage

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
    import hdlc_rx_pkg::*;
#(
    parameter int STUFF_RUN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic bit_in,
    output logic out_vld,
    output logic out_bit,
    output logic flag_evt,
    output logic abort_evt
);
    localparam int FLAG_RUN  = STUFF_RUN + 1;
    localparam int ABORT_RUN = STUFF_RUN + 2;
    localparam int DLY_D     = STUFF_RUN + 2;
    localparam int ONES_W    = $clog2(ABORT_RUN + 1);
    localparam int DCNT_W    = $clog2(DLY_D + 1);

    dfr_state_t        state_q, state_d;
    logic [ONES_W-1:0] ones_q, ones_d;
    logic [DLY_D-1:0]  dly_q, dly_d;
    logic [DCNT_W-1:0] dcnt_q, dcnt_d;
    logic              vld_d, bit_d, flag_d, abort_d;
    logic              at_stuff, at_flag, at_abort;

    assign at_stuff = (ones_q == ONES_W'(STUFF_RUN)) && !bit_in;
    assign at_flag  = (ones_q == ONES_W'(FLAG_RUN)) && !bit_in;
    assign at_abort = (ones_q == ONES_W'(FLAG_RUN)) && bit_in;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DF_HUNT;
            ones_q  <= '0;
            dly_q   <= '0;
            dcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            ones_q  <= ones_d;
            dly_q   <= dly_d;
            dcnt_q  <= dcnt_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        ones_d  = ones_q;
        dly_d   = dly_q;
        dcnt_d  = dcnt_q;
        vld_d   = 1'b0;
        bit_d   = 1'b0;
        flag_d  = 1'b0;
        abort_d = 1'b0;
        if (bit_en) begin
            if (bit_in) begin
                ones_d = (ones_q == ONES_W'(ABORT_RUN)) ? ones_q : ones_q + 1'b1;
            end else begin
                ones_d = '0;
            end
            unique case (state_q)
                DF_HUNT: begin
                    if (at_flag) begin
                        state_d = DF_OPEN;
                        dcnt_d  = '0;
                    end
                end
                DF_OPEN: begin
                    if (at_flag) begin
                        flag_d = 1'b1;
                        dcnt_d = '0;
                    end else if (at_abort) begin
                        abort_d = 1'b1;
                        state_d = DF_HUNT;
                        dcnt_d  = '0;
                    end else if (!at_stuff) begin
                        dly_d = {dly_q[DLY_D-2:0], bit_in};
                        if (dcnt_q == DCNT_W'(DLY_D)) begin
                            vld_d = 1'b1;
                            bit_d = dly_q[DLY_D-1];
                        end else begin
                            dcnt_d = dcnt_q + 1'b1;
                        end
                    end
                end
                default: state_d = DF_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld   <= 1'b0;
            out_bit   <= 1'b0;
            flag_evt  <= 1'b0;
            abort_evt <= 1'b0;
        end else begin
            out_vld   <= vld_d;
            out_bit   <= bit_d;
            flag_evt  <= flag_d;
            abort_evt <= abort_d;
        end
    end

endmodule

// File: rtl/hdlc_rx_packer.sv
module hdlc_rx_packer
    import hdlc_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld,
    input  logic              bit_val,
    input  logic              flag_evt,
    input  logic              abort_evt,
    output logic              byte_stb,
    output logic [DATA_W-1:0] byte_val,
    output logic              end_stb,
    output logic              end_err,
    output logic              abort_stb
);
    localparam int CNT_W = $clog2(DATA_W);

    pk_state_t         state_q, state_d;
    logic [DATA_W-1:0] sh_q, sh_d, val_d, assembled;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              byte_d, end_d, err_d, abort_d;

    assign assembled = {bit_val, sh_q[DATA_W-1:1]};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PK_EMPTY;
            sh_q    <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            sh_q    <= sh_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        sh_d    = sh_q;
        cnt_d   = cnt_q;
        val_d   = byte_val;
        byte_d  = 1'b0;
        end_d   = 1'b0;
        err_d   = 1'b0;
        abort_d = 1'b0;
        if (bit_vld) begin
            sh_d = assembled;
            if (cnt_q == CNT_W'(DATA_W - 1)) begin
                byte_d  = 1'b1;
                val_d   = assembled;
                cnt_d   = '0;
                state_d = PK_BUSY;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end else if (flag_evt || abort_evt) begin
            cnt_d = '0;
            unique case (state_q)
                PK_EMPTY: state_d = PK_EMPTY;
                PK_BUSY: begin
                    state_d = PK_EMPTY;
                    if (flag_evt) begin
                        end_d = 1'b1;
                        err_d = (cnt_q != '0);
                    end else begin
                        abort_d = 1'b1;
                    end
                end
                default: state_d = PK_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_stb  <= 1'b0;
            byte_val  <= '0;
            end_stb   <= 1'b0;
            end_err   <= 1'b0;
            abort_stb <= 1'b0;
        end else begin
            byte_stb  <= byte_d;
            byte_val  <= val_d;
            end_stb   <= end_d;
            end_err   <= err_d;
            abort_stb <= abort_d;
        end
    end

endmodule

// File: rtl/hdlc_rx_backend.sv
module hdlc_rx_backend
    import hdlc_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_val,
    input  logic              end_stb,
    input  logic              end_err,
    input  logic              abort_stb,
    input  logic              rd_req,
    output logic              avail,
    output logic [DATA_W-1:0] data,
    output logic              fvalid,
    output logic              ferr,
    output logic              fabort
);
    be_state_t         state_q, state_d;
    logic              avail_d, err_d, abt_d;
    logic [DATA_W-1:0] data_d;
    logic              take, overrun;

    assign take    = rd_req && avail;
    assign overrun = byte_stb && avail && !take;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BE_IDLE;
            avail   <= 1'b0;
            data    <= '0;
            ferr    <= 1'b0;
            fabort  <= 1'b0;
        end else begin
            state_q <= state_d;
            avail   <= avail_d;
            data    <= data_d;
            ferr    <= err_d;
            fabort  <= abt_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        avail_d = avail;
        data_d  = data;
        err_d   = ferr;
        abt_d   = fabort;
        if (byte_stb) begin
            data_d  = byte_val;
            avail_d = 1'b1;
            state_d = BE_LIVE;
            unique case (state_q)
                BE_LIVE: err_d = ferr || overrun;
                BE_IDLE, BE_DRAIN: begin
                    err_d = overrun;
                    abt_d = 1'b0;
                end
                default: err_d = overrun;
            endcase
        end else begin
            if (take) begin
                avail_d = 1'b0;
            end
            unique case (state_q)
                BE_IDLE: state_d = BE_IDLE;
                BE_LIVE: begin
                    if (end_stb) begin
                        err_d   = ferr || end_err;
                        state_d = BE_DRAIN;
                    end else if (abort_stb) begin
                        abt_d   = 1'b1;
                        state_d = BE_DRAIN;
                    end
                end
                BE_DRAIN: begin
                    if (!avail) begin
                        state_d = BE_IDLE;
                    end
                end
                default: state_d = BE_IDLE;
            endcase
        end
    end

    assign fvalid = (state_q != BE_IDLE);

endmodule

// File: rtl/hdlc_rx_core.sv
module hdlc_rx_core #(
    parameter int DATA_W    = 8,
    parameter int STUFF_RUN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_en,
    input  logic              ser_bit,
    input  logic              bk_rd,
    output logic [DATA_W-1:0] bk_data,
    output logic              bk_avail,
    output logic              frm_valid,
    output logic              frm_err,
    output logic              frm_abort,
    input  logic              wb_stb,
    input  logic              wb_we,
    output logic [DATA_W-1:0] wb_dat,
    output logic              wb_ack,
    output logic              wb_rty
);
    logic              dfr_vld, dfr_bit, dfr_flag, dfr_abort;
    logic              pk_byte_stb, pk_end_stb, pk_end_err, pk_abort_stb;
    logic [DATA_W-1:0] pk_byte_val;
    logic              rd_req;

    hdlc_rx_deframer #(.STUFF_RUN(STUFF_RUN)) u_dfr (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (ser_en),
        .bit_in    (ser_bit),
        .out_vld   (dfr_vld),
        .out_bit   (dfr_bit),
        .flag_evt  (dfr_flag),
        .abort_evt (dfr_abort)
    );

    hdlc_rx_packer #(.DATA_W(DATA_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_vld   (dfr_vld),
        .bit_val   (dfr_bit),
        .flag_evt  (dfr_flag),
        .abort_evt (dfr_abort),
        .byte_stb  (pk_byte_stb),
        .byte_val  (pk_byte_val),
        .end_stb   (pk_end_stb),
        .end_err   (pk_end_err),
        .abort_stb (pk_abort_stb)
    );

    hdlc_rx_backend #(.DATA_W(DATA_W)) u_be (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_stb  (pk_byte_stb),
        .byte_val  (pk_byte_val),
        .end_stb   (pk_end_stb),
        .end_err   (pk_end_err),
        .abort_stb (pk_abort_stb),
        .rd_req    (rd_req),
        .avail     (bk_avail),
        .data      (bk_data),
        .fvalid    (frm_valid),
        .ferr      (frm_err),
        .fabort    (frm_abort)
    );

    assign wb_ack = wb_stb && !wb_we;
    assign wb_rty = !bk_avail;
    assign wb_dat = bk_data;
    assign rd_req = bk_rd || wb_ack;

endmodule

// File: rtl/hdlc_rx_chk.sv
module hdlc_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic ser_en,
    input logic bk_rd,
    input logic wb_stb,
    input logic wb_we,
    input logic bk_avail,
    input logic frm_valid,
    input logic frm_err,
    input logic frm_abort,
    input logic dfr_vld,
    input logic dfr_flag,
    input logic dfr_abort,
    input logic pk_byte_stb,
    input logic pk_end_stb,
    input logic pk_end_err,
    input logic pk_abort_stb
);
    logic any_rd;
    assign any_rd = bk_rd || (wb_stb && !wb_we);

    // R4
    idle_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_en |=> !(dfr_vld || dfr_flag || dfr_abort));

    // R11
    hold_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bk_avail && !any_rd) |=> bk_avail);

    // R6
    avail_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bk_avail |-> frm_valid);

    // R8
    overrun_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_byte_stb && bk_avail && !any_rd) |=> frm_err);

    // R7
    residue_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_end_stb && pk_end_err) |=> frm_err);

    // R9
    abort_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pk_abort_stb |=> frm_abort);

    // R12
    wb_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_stb && !wb_we && bk_avail && !pk_byte_stb) |=> !bk_avail);

endmodule

bind hdlc_rx_core hdlc_rx_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ser_en       (ser_en),
    .bk_rd        (bk_rd),
    .wb_stb       (wb_stb),
    .wb_we        (wb_we),
    .bk_avail     (bk_avail),
    .frm_valid    (frm_valid),
    .frm_err      (frm_err),
    .frm_abort    (frm_abort),
    .dfr_vld      (dfr_vld),
    .dfr_flag     (dfr_flag),
    .dfr_abort    (dfr_abort),
    .pk_byte_stb  (pk_byte_stb),
    .pk_end_stb   (pk_end_stb),
    .pk_end_err   (pk_end_err),
    .pk_abort_stb (pk_abort_stb)
);

// File: tb/hdlc_rx_core_bench.sv
module hdlc_rx_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_en = 1'b0;
    logic       ser_bit = 1'b0;
    logic       mon_rd = 1'b0;
    logic       man_rd = 1'b0;
    logic       bk_rd;
    logic       wb_stb = 1'b0;
    logic       wb_we = 1'b0;
    logic [7:0] bk_data, wb_dat;
    logic       bk_avail, frm_valid, frm_err, frm_abort, wb_ack, wb_rty;

    int         total = 0;
    int         bad = 0;
    int         tx_ones = 0;
    bit         mon_on = 1'b1;
    bit         gap_on = 1'b0;
    logic [7:0] exp_q[$];

    assign bk_rd = mon_rd || man_rd;

    always #5 clk = ~clk;

    hdlc_rx_core u_hdlc_rx_core (
        .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_bit(ser_bit),
        .bk_rd(bk_rd), .bk_data(bk_data), .bk_avail(bk_avail),
        .frm_valid(frm_valid), .frm_err(frm_err), .frm_abort(frm_abort),
        .wb_stb(wb_stb), .wb_we(wb_we), .wb_dat(wb_dat),
        .wb_ack(wb_ack), .wb_rty(wb_rty)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // monitor: pops the scoreboard as bytes appear
    initial begin
        forever begin
            @(negedge clk);
            mon_rd = 1'b0;
            if (mon_on && bk_avail) begin
                check(frm_valid == 1'b1, "R6 valid while byte waits", frm_valid, 1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2/R5 unexpected byte", bk_data, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(bk_data == e, "R2 byte order/value", bk_data, e);
                end
                mon_rd = 1'b1;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    task automatic put_bit(input bit b);
        if (gap_on) begin
            repeat (2) begin
                @(negedge clk);
                ser_en  = 1'b0;
                ser_bit = 1'($urandom);
            end
        end
        @(negedge clk);
        ser_en  = 1'b1;
        ser_bit = b;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            ser_en  = 1'b0;
            ser_bit = 1'($urandom);
        end
    endtask

    task automatic send_flag();
        put_bit(1'b0);
        repeat (6) put_bit(1'b1);
        put_bit(1'b0);
        tx_ones = 0;
    endtask

    task automatic send_data_bit(input bit b);
        put_bit(b);
        if (b) begin
            tx_ones++;
            if (tx_ones == 5) begin
                put_bit(1'b0);
                tx_ones = 0;
            end
        end else begin
            tx_ones = 0;
        end
    endtask

    task automatic send_byte(input logic [7:0] v, input bit push);
        for (int i = 0; i < 8; i++) send_data_bit(v[i]);
        if (push) exp_q.push_back(v);
    endtask

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        check(bk_avail == 1'b0, "R1 avail", bk_avail, 0);
        check(frm_valid == 1'b0, "R1 valid", frm_valid, 0);
        check(frm_err == 1'b0, "R1 err", frm_err, 0);
        check(frm_abort == 1'b0, "R1 abort", frm_abort, 0);
        check(wb_rty == 1'b1, "R1 retry", wb_rty, 1);
        rst_n = 1'b1;
        idle(3);

        // R2: plain frame
        send_flag();
        send_byte(8'hA5, 1); send_byte(8'h3C, 1); send_byte(8'h81, 1);
        send_flag();
        idle(8);
        check(exp_q.size() == 0, "R2 all bytes delivered", exp_q.size(), 0);
        check(frm_valid == 1'b0, "R6 valid falls after drain", frm_valid, 0);
        check(frm_err == 1'b0, "R2 no error", frm_err, 0);

        // R3: zero deletion with ones-heavy payload
        send_flag();
        send_byte(8'hFF, 1); send_byte(8'h7E, 1); send_byte(8'h1F, 1); send_byte(8'hF8, 1);
        send_flag();
        idle(8);
        check(exp_q.size() == 0, "R3 stuffed bytes delivered", exp_q.size(), 0);
        check(frm_err == 1'b0, "R3 no error", frm_err, 0);

        // R4: gapped enable with random line data
        gap_on = 1'b1;
        send_flag();
        send_byte(8'h5A, 1); send_byte(8'hC3, 1);
        send_flag();
        gap_on = 1'b0;
        idle(8);
        check(exp_q.size() == 0, "R4 gapped bytes delivered", exp_q.size(), 0);
        check(frm_err == 1'b0, "R4 no error", frm_err, 0);

        // R5: back-to-back delimiters
        repeat (4) send_flag();
        idle(6);
        check(frm_valid == 1'b0, "R5 no frame from flags", frm_valid, 0);
        check(bk_avail == 1'b0, "R5 no byte from flags", bk_avail, 0);

        // R7: bit count not a multiple of eight
        send_flag();
        send_byte(8'h12, 1); send_byte(8'h34, 1);
        send_data_bit(1'b1); send_data_bit(1'b0); send_data_bit(1'b1);
        send_flag();
        idle(8);
        check(exp_q.size() == 0, "R7 whole bytes delivered", exp_q.size(), 0);
        check(frm_err == 1'b1, "R7 short frame error", frm_err, 1);
        check(frm_valid == 1'b0, "R7 valid low", frm_valid, 0);

        // R10: next frame clears the error
        send_flag();
        send_byte(8'h66, 1);
        send_flag();
        idle(8);
        check(frm_err == 1'b0, "R10 error cleared", frm_err, 0);

        // R9: idle ones after a closed frame raise no abort
        repeat (10) put_bit(1'b1);
        idle(6);
        check(frm_abort == 1'b0, "R9 idle ones no abort", frm_abort, 0);

        // R9: abort inside a frame
        send_flag();
        send_byte(8'h11, 1); send_byte(8'h22, 1);
        send_byte(8'h00, 0);
        repeat (7) put_bit(1'b1);
        idle(8);
        check(exp_q.size() == 0, "R9 bytes before abort", exp_q.size(), 0);
        check(frm_abort == 1'b1, "R9 abort flagged", frm_abort, 1);
        check(frm_valid == 1'b0, "R9 valid low", frm_valid, 0);
        send_flag();
        idle(4);
        check(frm_abort == 1'b1, "R10 abort held", frm_abort, 1);
        send_byte(8'h33, 1);
        send_flag();
        idle(8);
        check(frm_abort == 1'b0, "R10 abort cleared", frm_abort, 0);

        // R8: overrun, reader stalled
        mon_on = 1'b0;
        send_flag();
        send_byte(8'h01, 0); send_byte(8'h02, 0); send_byte(8'h03, 0);
        send_flag();
        idle(8);
        check(bk_avail == 1'b1, "R8 byte waiting", bk_avail, 1);
        check(bk_data == 8'h03, "R8 newest byte kept", bk_data, 8'h03);
        check(frm_err == 1'b1, "R8 overrun error", frm_err, 1);
        check(frm_valid == 1'b1, "R6 valid while draining", frm_valid, 1);
        idle(20);
        check(bk_avail == 1'b1, "R11 avail held", bk_avail, 1);
        @(negedge clk); man_rd = 1'b1;
        @(negedge clk); man_rd = 1'b0;
        check(bk_avail == 1'b0, "R11 read clears avail", bk_avail, 0);
        @(negedge clk); @(negedge clk);
        check(frm_valid == 1'b0, "R6 valid falls after last read", frm_valid, 0);

        // R12: bus slave access
        send_flag();
        send_byte(8'h9C, 0);
        send_flag();
        idle(8);
        check(wb_rty == 1'b0, "R12 retry low with byte", wb_rty, 0);
        @(negedge clk); wb_stb = 1'b1; wb_we = 1'b1;
        #1 check(wb_ack == 1'b0, "R12 no ack on write", wb_ack, 0);
        @(negedge clk);
        check(bk_avail == 1'b1, "R12 write leaves byte", bk_avail, 1);
        wb_we = 1'b0;
        #1 check(wb_ack == 1'b1, "R12 ack on read", wb_ack, 1);
        check(wb_dat == 8'h9C, "R12 read data", wb_dat, 8'h9C);
        @(negedge clk); wb_stb = 1'b0;
        #1 check(bk_avail == 1'b0, "R12 read consumes", bk_avail, 0);
        check(wb_rty == 1'b1, "R12 retry when empty", wb_rty, 1);
        mon_on = 1'b1;
        idle(4);

        finish_run();
    end

endmodule